// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block merges two kinds of interrupt source into one target priority level. The first kind is a software request register. Each valid bit in it asks for a software level. The second kind is a set of external lines, and each line carries its own pending count. The block finds the highest pending level and compares it with a current priority level register that the block also holds. It raises a take request when the target is strictly above that level. The take request is held off entirely while the core runs privileged code.

Software request bits sit at positions SW_LO..SW_HI (default 4..18). Bit i stands for level i − SW_LO + 1, which gives levels 1..15. External line k sits at summary position EXT_BASE + k (default 20..31) and stands for that same level. Each external line has an up/down counter, so several agents can share one line: a line stays pending until every assert has been matched by a deassert. When a take occurs, the pending-source summary and the winning level are captured into output registers on the same clock edge that raises the take output.

Top module: `irq_level_arbiter`

## Requirements
- R1: A software request write replaces the register with the written data masked to bits 4..18; every other bit reads back as zero on `sw_req_o`.
- R2: A pending software bit i counts as level i − 3, so bit 4 is level 1 and bit 18 is level 15.
- R3: A pending external line k counts as level 20 + k (line 0 is level 20, line 11 is level 31).
- R4: The target level is the highest pending level. Any pending external line beats every software request.
- R5: The summary has a 1 at bit i for each pending software bit i, and a 1 at bit 20 + k for each pending external line k. All other bits are 0.
- R6: `take_o` is 1 one cycle after a state in which the target level is nonzero and strictly greater than the current level. It is 0 otherwise, including when the two levels are equal.
- R7: While `priv_i` is 1, `take_o` is 0 on the following cycle, whatever is pending.
- R8: Each assert on a line adds one to its count. Each deassert subtracts one. The line stays pending until its count is back at zero.
- R9: A current-level write keeps only the low 5 bits of the data, which read back on `ipl_o`.
- R10: `sum_o` and `lvl_o` load the summary and target on every edge that sets `take_o`, and hold their value on every other edge. All outputs are zero after reset.
- R11: A deassert on a line whose count is zero leaves the count at zero and sets `err_o`. Only reset clears `err_o`.
- R12: An assert and a deassert on the same line in the same cycle leave its count unchanged. An assert on a line already at the maximum count (7) is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we_i | input | 1 | Software request register write strobe |
| sw_wdata_i | input | 32 | Software request write data |
| ipl_we_i | input | 1 | Current level write strobe |
| ipl_wdata_i | input | 32 | Current level write data |
| ext_set_i | input | 12 | Per-line assert pulses |
| ext_clr_i | input | 12 | Per-line deassert pulses |
| priv_i | input | 1 | Core is running privileged code |
| take_o | output | 1 | Take-interrupt request |
| sum_o | output | 32 | Summary captured at the last take |
| lvl_o | output | 5 | Winning level captured at the last take |
| sw_req_o | output | 32 | Software request register contents |
| ipl_o | output | 5 | Current level register contents |
| err_o | output | 1 | Sticky deassert-at-zero error |

## Verification
Two functions can land in the same cycle: an assert and a deassert on the same external line, and a capture of the take result together with a write that changes the state it was computed from. The bench provokes the first by pulsing both strobes of one line together. It then removes that line's one earlier assert and checks that the line goes idle on exactly that deassert. This shows the count neither rose nor fell during the shared cycle. For the second, the bench changes the privilege flag or the current level while an older state is still pending. Its model captures the latched outputs from the pre-write state and then again from the post-write state, and compares `sum_o` and `lvl_o` against the final capture.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Decoded action of a line counter for one cycle.
  typedef enum logic [1:0] {
    CNT_HOLD = 2'b00,
    CNT_UP   = 2'b01,
    CNT_DOWN = 2'b10
  } cnt_op_e;
endpackage

// File: rtl/irq_line_counter.sv
module irq_line_counter
  import irq_arb_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic pend_o,
  output logic under_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  cnt_op_e          op;

  always_comb begin
    op      = CNT_HOLD;
    under_o = 1'b0;
    if (inc_i && !dec_i && (cnt_q != CNT_MAX)) op = CNT_UP;
    if (dec_i && !inc_i) begin
      if (cnt_q != '0) op = CNT_DOWN;
      else             under_o = 1'b1;
    end
    cnt_en = (op != CNT_HOLD);
    unique case (op)
      CNT_UP:   cnt_d = cnt_q + 1'b1;
      CNT_DOWN: cnt_d = cnt_q - 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pend_o = (cnt_q != '0);

  // R12: a full counter never wraps to zero.
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q != '0));

  // R11: a lone deassert at zero leaves the count at zero.
  p_zero_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && dec_i && !inc_i) |=> (cnt_q == '0));

  // R12: simultaneous strobes leave the count unchanged.
  p_both_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_level_resolve.sv
module irq_level_resolve #(
  parameter int unsigned SW_LO    = 4,
  parameter int unsigned SW_HI    = 18,
  parameter int unsigned EXT_BASE = 20,
  parameter int unsigned EXT_NUM  = 12,
  parameter int unsigned LVL_W    = 5,
  localparam int unsigned SUM_W   = EXT_BASE + EXT_NUM
) (
  input  logic [SUM_W-1:0]   sw_req_i,
  input  logic [EXT_NUM-1:0] ext_pend_i,
  output logic [SUM_W-1:0]   sum_o,
  output logic [LVL_W-1:0]   tgt_o
);
  // Ascending scan: a later (higher) pending level overwrites the
  // previous one; external lines are scanned after software bits.
  always_comb begin
    sum_o = '0;
    tgt_o = '0;
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (sw_req_i[i]) begin
        sum_o[i] = 1'b1;
        tgt_o    = LVL_W'(i - SW_LO + 1);
      end
    end
    for (int k = 0; k < EXT_NUM; k++) begin
      if (ext_pend_i[k]) begin
        sum_o[EXT_BASE + k] = 1'b1;
        tgt_o               = LVL_W'(EXT_BASE + k);
      end
    end
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int unsigned SW_LO    = 4,
  parameter int unsigned SW_HI    = 18,
  parameter int unsigned EXT_BASE = 20,
  parameter int unsigned EXT_NUM  = 12,
  parameter int unsigned LVL_W    = 5,
  parameter int unsigned CNT_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sw_we_i,
  input  logic [EXT_BASE+EXT_NUM-1:0]   sw_wdata_i,
  input  logic                          ipl_we_i,
  input  logic [EXT_BASE+EXT_NUM-1:0]   ipl_wdata_i,
  input  logic [EXT_NUM-1:0]            ext_set_i,
  input  logic [EXT_NUM-1:0]            ext_clr_i,
  input  logic                          priv_i,
  output logic                          take_o,
  output logic [EXT_BASE+EXT_NUM-1:0]   sum_o,
  output logic [LVL_W-1:0]              lvl_o,
  output logic [EXT_BASE+EXT_NUM-1:0]   sw_req_o,
  output logic [LVL_W-1:0]              ipl_o,
  output logic                          err_o
);
  localparam int unsigned SUM_W = EXT_BASE + EXT_NUM;
  localparam logic [SUM_W-1:0] SW_MASK =
    ((SUM_W'(1) << (SW_HI + 1)) - SUM_W'(1)) & ~((SUM_W'(1) << SW_LO) - SUM_W'(1));

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // External line counters.
  logic [EXT_NUM-1:0] ext_pend, ext_under;
  for (genvar g = 0; g < EXT_NUM; g++) begin : g_line
    irq_line_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .inc_i  (ext_set_i[g]),
      .dec_i  (ext_clr_i[g]),
      .pend_o (ext_pend[g]),
      .under_o(ext_under[g])
    );
  end

  // State registers.
  logic [SUM_W-1:0] sw_q, sw_d;
  logic [LVL_W-1:0] ipl_q, ipl_d;
  logic             take_q, take_d;
  logic [SUM_W-1:0] lat_sum_q;
  logic [LVL_W-1:0] lat_lvl_q;
  logic             err_q, err_d, err_en;

  logic [SUM_W-1:0] cur_sum;
  logic [LVL_W-1:0] cur_tgt;

  irq_level_resolve #(
    .SW_LO(SW_LO), .SW_HI(SW_HI), .EXT_BASE(EXT_BASE),
    .EXT_NUM(EXT_NUM), .LVL_W(LVL_W)
  ) u_resolve (
    .sw_req_i  (sw_q),
    .ext_pend_i(ext_pend),
    .sum_o     (cur_sum),
    .tgt_o     (cur_tgt)
  );

  always_comb begin
    sw_d   = sw_wdata_i & SW_MASK;
    ipl_d  = ipl_wdata_i[LVL_W-1:0];
    take_d = !priv_i && (cur_tgt != '0) && (cur_tgt > ipl_q);
    err_en = |ext_under;
    err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sw_q      <= '0;
      ipl_q     <= '0;
      take_q    <= 1'b0;
      lat_sum_q <= '0;
      lat_lvl_q <= '0;
      err_q     <= 1'b0;
    end else begin
      take_q <= take_d;
      if (sw_we_i)  sw_q  <= sw_d;
      if (ipl_we_i) ipl_q <= ipl_d;
      if (take_d) begin
        lat_sum_q <= cur_sum;
        lat_lvl_q <= cur_tgt;
      end
      if (err_en) err_q <= err_d;
    end
  end

  assign take_o   = take_q;
  assign sum_o    = lat_sum_q;
  assign lvl_o    = lat_lvl_q;
  assign sw_req_o = sw_q;
  assign ipl_o    = ipl_q;
  assign err_o    = err_q;

  // R7: privileged code blocks the next take.
  p_priv_block_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    priv_i |=> !take_o);

  // R6: a taken level lies strictly above the level it was compared with.
  p_above_ipl_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take_o |-> (lvl_o > $past(ipl_q)));

  // R10: captured outputs hold while no take is raised.
  p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !take_o |-> ($stable(lvl_o) && $stable(sum_o)));

  // R11: the error flag is sticky.
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_o |=> err_o);

  // R1: software register never holds bits outside the valid window.
  p_sw_window_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sw_we_i |=> ((sw_req_o & ~SW_MASK) == '0));
endmodule

// File: tb/irq_level_arbiter_tb.sv
module irq_level_arbiter_tb;
  localparam int EXT_NUM = 12;
  localparam int EXT_BASE = 20;
  localparam int CMAX = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_we, ipl_we, priv;
  logic [31:0] sw_wd, ipl_wd;
  logic [11:0] eset, eclr;
  logic        take;
  logic [31:0] sum, swr;
  logic [4:0]  lvl, ipl;
  logic        err;

  always #2 clk = ~clk;

  irq_level_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .sw_we_i(sw_we), .sw_wdata_i(sw_wd),
    .ipl_we_i(ipl_we), .ipl_wdata_i(ipl_wd), .ext_set_i(eset),
    .ext_clr_i(eclr), .priv_i(priv), .take_o(take), .sum_o(sum),
    .lvl_o(lvl), .sw_req_o(swr), .ipl_o(ipl), .err_o(err)
  );

  typedef struct {
    int          due;
    logic        take;
    logic [31:0] sum;
    logic [4:0]  lvl;
    logic [31:0] sw;
    logic [4:0]  ipl;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Model state
  logic [31:0] m_sw = '0;
  logic [4:0]  m_ipl = '0, m_lvl = '0;
  logic [31:0] m_sum = '0;
  logic        m_err = 1'b0;
  int          m_cnt [EXT_NUM];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic void model_eval(input logic pv, output logic tk,
                                     output logic [31:0] s, output logic [4:0] l);
    s = '0; l = '0;
    for (int i = 4; i <= 18; i++)
      if (m_sw[i]) begin s[i] = 1'b1; l = 5'(i - 3); end
    for (int k = 0; k < EXT_NUM; k++)
      if (m_cnt[k] != 0) begin s[EXT_BASE + k] = 1'b1; l = 5'(EXT_BASE + k); end
    tk = !pv && (l != 0) && (l > m_ipl);
  endfunction

  // Driver: one stimulus cycle then one idle cycle; pushes expected item.
  task automatic op(input logic swe, input logic [31:0] swd, input logic iwe,
                    input logic [31:0] iwd, input logic [11:0] as,
                    input logic [11:0] ds, input logic pv, input string tag);
    logic tk; logic [31:0] s; logic [4:0] l;
    int k0;
    exp_t e;
    k0 = cyc;
    sw_we = swe; sw_wd = swd; ipl_we = iwe; ipl_wd = iwd;
    eset = as; eclr = ds; priv = pv;
    // capture evaluated on the stimulus edge uses the old state
    model_eval(pv, tk, s, l);
    if (tk) begin m_sum = s; m_lvl = l; end
    if (swe) m_sw = swd & 32'h0007_FFF0;
    if (iwe) m_ipl = iwd[4:0];
    for (int k = 0; k < EXT_NUM; k++) begin
      if (as[k] && !ds[k] && m_cnt[k] != CMAX) m_cnt[k]++;
      else if (ds[k] && !as[k]) begin
        if (m_cnt[k] != 0) m_cnt[k]--;
        else m_err = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    sw_we = 0; ipl_we = 0; eset = '0; eclr = '0;
    model_eval(pv, tk, s, l);
    if (tk) begin m_sum = s; m_lvl = l; end
    e.due = k0 + 2; e.take = tk; e.sum = m_sum; e.lvl = m_lvl;
    e.sw = m_sw; e.ipl = m_ipl; e.err = m_err; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares items as the design produces them.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " take"}, {31'b0, take}, {31'b0, e.take});
      chk({e.tag, " R5/R10 sum"}, sum, e.sum);
      chk({e.tag, " R4/R10 lvl"}, {27'b0, lvl}, {27'b0, e.lvl});
      chk({e.tag, " R1 sw_req"}, swr, e.sw);
      chk({e.tag, " R9 ipl"}, {27'b0, ipl}, {27'b0, e.ipl});
      chk({e.tag, " R11 err"}, {31'b0, err}, {31'b0, e.err});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < EXT_NUM; k++) m_cnt[k] = 0;
    rst_n = 0; sw_we = 0; ipl_we = 0; sw_wd = '0; ipl_wd = '0;
    eset = '0; eclr = '0; priv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 reset take", {31'b0, take}, 32'h0);
    chk("R10 reset sum", sum, 32'h0);
    chk("R10 reset lvl", {27'b0, lvl}, 32'h0);
    chk("R10 reset sw", swr, 32'h0);
    chk("R10 reset err", {31'b0, err}, 32'h0);

    op(0, 0, 1, 32'hFFFF_FFE5, '0, '0, 0, "R9 mask level write");
    op(0, 0, 1, 32'h3F, '0, '0, 0, "R9 level 31");
    op(1, 32'hFFFF_FFFF, 0, 0, '0, '0, 0, "R1 mask sw write, R6 below ipl");
    op(0, 0, 1, 14, '0, '0, 0, "R2 R6 level 15 over 14");
    op(0, 0, 1, 15, '0, '0, 0, "R6 equal level no take R10 hold");
    op(0, 0, 1, 0, '0, '0, 0, "R6 ipl zero");
    op(1, 32'h0000_0010, 0, 0, '0, '0, 0, "R2 bit4 level1");
    op(0, 0, 0, 0, '0, '0, 1, "R7 priv blocks");
    op(0, 0, 0, 0, 12'h001, '0, 0, "R3 R4 R5 line0 level20");
    op(0, 0, 0, 0, 12'h001, '0, 0, "R8 second assert");
    op(0, 0, 0, 0, '0, 12'h001, 0, "R8 still pending");
    op(0, 0, 0, 0, '0, 12'h001, 0, "R8 count zero");
    op(0, 0, 0, 0, '0, 12'h001, 0, "R11 deassert at zero");
    op(0, 0, 0, 0, 12'h808, '0, 0, "R4 R3 line11 level31");
    op(0, 0, 0, 0, 12'h008, 12'h008, 0, "R12 same-cycle strobes");
    op(0, 0, 0, 0, '0, 12'h800, 0, "R4 line11 removed");
    op(0, 0, 0, 0, '0, 12'h008, 0, "R12 line3 count was one");
    for (int n = 0; n < 9; n++)
      op(0, 0, 0, 0, 12'h020, '0, 0, "R12 saturate assert");
    for (int n = 0; n < 7; n++)
      op(0, 0, 0, 0, '0, 12'h020, 0, "R12 R8 drain saturated line");
    op(0, 0, 1, 2, '0, '0, 0, "R6 ipl above sw level");
    op(1, 32'h0004_0000, 0, 0, '0, '0, 0, "R2 bit18 level15");
    op(1, 32'h0, 0, 0, '0, '0, 0, "R6 nothing pending");
    repeat (4) @(negedge clk);
    chk("R11 err stays set", {31'b0, err}, 32'h1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule